// File: doc/BRIEF.md
# Configurable Registered Output Macrocell

This block is a single output cell placed after a sum-of-products array. It receives the OR sum of its product terms, a dedicated output-enable term, and the shared clock, preset and clear terms. A four-bit configuration word sets three things: whether the pin carries the sum directly or a registered copy of it, whether that value is inverted, and which of three signals goes back into the array.

The cell contains one D flip-flop. The preset term acts only at a rising clock edge. The clear term acts at once, with no clock edge needed. If both are asserted, clear wins. The pin driver is enabled by the cell's own enable term. When the driver is off, the pin carries whatever the outside world applies.

Top module: `omc_cell`

## Requirements
- R1: While `rst_ni` is low, the flip-flop holds 0. Assertion is asynchronous. With configuration 4'b0101 and the enable term high, both `pin_o` and `fb_o` read 0.
- R2: When neither preset nor clear is asserted, a rising clock edge loads `sum_i` into the flip-flop.
- R3: An asserted preset term sets the flip-flop to 1 at the next rising edge, and not before that edge.
- R4: An asserted clear term forces the flip-flop to 0 immediately, without waiting for a clock edge, and holds it at 0 while it stays asserted.
- R5: When clear and preset are asserted together, the flip-flop goes to 0.
- R6: With `cfg_i[0]`=0 the output is combinational: `pin_o` = `sum_i` XOR `cfg_i[1]`, in the same cycle.
- R7: With `cfg_i[0]`=1 the output is registered: `pin_o` = flip-flop XOR `cfg_i[1]`.
- R8: `pin_oe_o` follows `oe_term_i` in every configuration.
- R9: `cfg_i[3:2]` selects `fb_o`. 2'b01 gives the flip-flop value, uninverted. 2'b10 gives `sum_i`, uninverted. 2'b00 and 2'b11 both give the pin value.
- R10: The pin value used for feedback is `pin_o` when `oe_term_i`=1 and `pin_i` when `oe_term_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock term |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sum_i | input | 1 | OR sum from the array |
| oe_term_i | input | 1 | Per-cell output-enable term |
| preset_term_i | input | 1 | Global synchronous preset term |
| clear_term_i | input | 1 | Global asynchronous clear term |
| cfg_i | input | 4 | Configuration: [0] registered, [1] invert, [3:2] feedback select |
| pin_i | input | 1 | Value seen on the pin from outside |
| pin_o | output | 1 | Value driven on the pin |
| pin_oe_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback to the array |

## Verification
The combinational results (R6, R8, R9, R10) have no register in their path. The bench therefore checks them 1 ns after each input change, with the clock held still. Flip-flop results (R2, R3, R5, R7) appear one edge later. They are sampled a few nanoseconds after that rising edge, before the next falling edge drives new inputs. The clear term (R4) is sampled 2 ns after it is driven at a falling edge, well before the next rising edge. This means any dependence on a clock edge would show up as a miscompare. Reset (R1) is likewise checked between edges.

// File: rtl/omc_pkg.sv
package omc_pkg;
  localparam int unsigned CFG_W = 4;
  localparam int unsigned FB_W  = 2;

  typedef enum logic [FB_W-1:0] {
    FB_PIN     = 2'b00,
    FB_REG     = 2'b01,
    FB_SUM     = 2'b10,
    FB_PIN_ALT = 2'b11
  } fb_sel_e;

  typedef struct packed {
    fb_sel_e fb;
    logic    inv;
    logic    reg_en;
  } cell_cfg_t;
endpackage

// File: rtl/omc_dff.sv
module omc_dff #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // clear is a product term and acts without a clock edge
  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (clr_i)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else             q_o <= d_i;
  end
endmodule

// File: rtl/omc_out_path.sv
module omc_out_path (
  input  logic sum_i,
  input  logic q_i,
  input  logic reg_en_i,
  input  logic inv_i,
  output logic data_o
);
  logic sel;
  always_comb begin
    sel    = reg_en_i ? q_i : sum_i;
    data_o = sel ^ inv_i;
  end
endmodule

// File: rtl/omc_fb_path.sv
module omc_fb_path
  import omc_pkg::*;
(
  input  fb_sel_e sel_i,
  input  logic    q_i,
  input  logic    sum_i,
  input  logic    pin_val_i,
  output logic    fb_o
);
  always_comb begin
    unique case (sel_i)
      FB_REG:  fb_o = q_i;
      FB_SUM:  fb_o = sum_i;
      default: fb_o = pin_val_i;
    endcase
  end
endmodule

// File: rtl/omc_cell.sv
module omc_cell
  import omc_pkg::*;
#(
  parameter int unsigned CFG_BITS = CFG_W,
  parameter logic        Q_RST    = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sum_i,
  input  logic                oe_term_i,
  input  logic                preset_term_i,
  input  logic                clear_term_i,
  input  logic [CFG_BITS-1:0] cfg_i,
  input  logic                pin_i,
  output logic                pin_o,
  output logic                pin_oe_o,
  output logic                fb_o
);
  cell_cfg_t cfg;
  logic      q_q;
  logic      pin_val;

  assign cfg = cell_cfg_t'(cfg_i[CFG_W-1:0]);

  omc_dff #(.RST_VAL(Q_RST)) u_dff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sum_i),
    .set_i (preset_term_i),
    .clr_i (clear_term_i),
    .q_o   (q_q)
  );

  omc_out_path u_out (
    .sum_i   (sum_i),
    .q_i     (q_q),
    .reg_en_i(cfg.reg_en),
    .inv_i   (cfg.inv),
    .data_o  (pin_o)
  );

  assign pin_oe_o = oe_term_i;
  assign pin_val  = oe_term_i ? pin_o : pin_i;

  omc_fb_path u_fb (
    .sel_i    (cfg.fb),
    .q_i      (q_q),
    .sum_i    (sum_i),
    .pin_val_i(pin_val),
    .fb_o     (fb_o)
  );
endmodule

// File: rtl/omc_cell_chk.sv
module omc_cell_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sum_i,
  input logic       oe_term_i,
  input logic       preset_term_i,
  input logic       clear_term_i,
  input logic [3:0] cfg_i,
  input logic       pin_o,
  input logic       fb_o,
  input logic       q_q
);
  AST_LOAD_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preset_term_i && !clear_term_i) |=> (q_q == $past(sum_i) || clear_term_i)); // R2
  AST_PRESET_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preset_term_i && !clear_term_i) |=> (q_q || clear_term_i)); // R3
  AST_CLEAR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_term_i |-> !q_q); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_term_i && preset_term_i) |=> !q_q || !clear_term_i); // R5
  AST_REG_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i[0] |-> (pin_o == (q_q ^ cfg_i[1]))); // R7
  AST_FB_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[3:2] == 2'b01) |-> (fb_o == q_q)); // R9
  AST_FB_PIN_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_term_i && !cfg_i[3] && !cfg_i[2]) |-> (fb_o == pin_o)); // R10
endmodule

bind omc_cell omc_cell_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sum_i        (sum_i),
  .oe_term_i    (oe_term_i),
  .preset_term_i(preset_term_i),
  .clear_term_i (clear_term_i),
  .cfg_i        (cfg_i),
  .pin_o        (pin_o),
  .fb_o         (fb_o),
  .q_q          (q_q)
);

// File: tb/sim_omc_cell.sv
`timescale 1ns/1ps
module sim_omc_cell;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       sum_i, oe_term_i, preset_term_i, clear_term_i, pin_i;
  logic [3:0] cfg_i;
  logic       pin_o, pin_oe_o, fb_o;

  int vectors = 0;
  int miscompares = 0;
  logic qm;

  omc_cell u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sum_i(sum_i), .oe_term_i(oe_term_i),
    .preset_term_i(preset_term_i), .clear_term_i(clear_term_i), .cfg_i(cfg_i),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .fb_o(fb_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string rq, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b (cfg=%b sum=%b oe=%b pin=%b q=%b)",
               rq, act, exp, cfg_i, sum_i, oe_term_i, pin_i, qm);
    end
  endtask

  function automatic logic exp_pin();
    return (cfg_i[0] ? qm : sum_i) ^ cfg_i[1];
  endfunction

  function automatic logic exp_fb();
    logic pv;
    pv = oe_term_i ? exp_pin() : pin_i;
    case (cfg_i[3:2])
      2'b01:   return qm;
      2'b10:   return sum_i;
      default: return pv;
    endcase
  endfunction

  task automatic check_all();
    chk(cfg_i[0] ? "R7 pin" : "R6 pin", pin_o, exp_pin());
    chk("R8 oe", pin_oe_o, oe_term_i);
    chk((cfg_i[3:2] == 2'b00 || cfg_i[3:2] == 2'b11) ? "R9/R10 fb" : "R9 fb", fb_o, exp_fb());
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    rst_ni = 1'b0; sum_i = 1'b1; oe_term_i = 1'b1; preset_term_i = 1'b0;
    clear_term_i = 1'b0; pin_i = 1'b1; cfg_i = 4'b0101; qm = 1'b0;
    repeat (2) @(posedge clk_i);
    #3;
    chk("R1 pin", pin_o, 1'b0);
    chk("R1 fb", fb_o, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;

    // exhaustive sweep: configuration x stored bit x sum/oe/pin
    for (int c = 0; c < 16; c++) begin
      for (int q = 0; q < 2; q++) begin
        @(negedge clk_i);
        cfg_i = c[3:0]; sum_i = q[0]; preset_term_i = 1'b0; clear_term_i = 1'b0;
        @(posedge clk_i);
        qm = q[0];
        #1;
        for (int v = 0; v < 8; v++) begin
          sum_i = v[0]; oe_term_i = v[1]; pin_i = v[2];
          #1;
          check_all();
        end
      end
    end

    // register sequencing: load, preset, clear, both
    lfsr = 8'hA5;
    cfg_i = 4'b0101; oe_term_i = 1'b1;
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      @(negedge clk_i);
      sum_i = lfsr[0]; preset_term_i = (lfsr[4:3] == 2'b00) || (lfsr[6:5] == 2'b11 && lfsr[2:1] == 2'b00);
      clear_term_i = (lfsr[2:1] == 2'b00);
      #2;
      if (clear_term_i) begin
        qm = 1'b0;
        chk("R4 async clear", pin_o, 1'b0);
      end else begin
        chk("R3 no early preset", pin_o, qm);
      end
      @(posedge clk_i);
      if (clear_term_i)       qm = 1'b0;
      else if (preset_term_i) qm = 1'b1;
      else                    qm = sum_i;
      #3;
      if (clear_term_i && preset_term_i) chk("R5 clear wins", pin_o, qm);
      else if (clear_term_i)             chk("R4 clear held", pin_o, qm);
      else if (preset_term_i)            chk("R3 preset", pin_o, qm);
      else                               chk("R2 load", pin_o, qm);
      chk("R9 fb reg", fb_o, qm);
    end

    // inverted registered output and asynchronous reset mid-cycle
    @(negedge clk_i);
    cfg_i = 4'b0111; preset_term_i = 1'b1; clear_term_i = 1'b0;
    @(posedge clk_i); qm = 1'b1; #3;
    chk("R7 inverted", pin_o, 1'b0);
    @(negedge clk_i); preset_term_i = 1'b0; sum_i = 1'b1;
    #2 rst_ni = 1'b0; qm = 1'b0;
    #2 chk("R1 async reset", pin_o, 1'b1);
    @(negedge clk_i) rst_ni = 1'b1;
    #2;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule